// File: doc/BRIEF.md
# Arithmetic Microoperation Unit

This block computes one of eight arithmetic microoperations on two unsigned operands using a single binary adder. A two-bit operation select chooses the adder's second operand from four sources: the B operand, its bitwise inverse, all zeros or all ones. A separate carry input feeds the adder's carry-in directly. The eight combinations give add, add plus one, subtract with borrow, true subtract, transfer, increment, decrement and a second transfer.

The sum and the adder's carry-out are available combinationally. An optional result register, enabled by a parameter, captures the sum on a rising clock edge when a load strobe is high. This lets a surrounding datapath perform register-transfer steps such as "destination takes first source plus second source".

Top module: `arith_micro_unit`

## Requirements
- R1: With op_sel = 2'b00, sum_out equals the low WIDTH bits of a_in + b_in + carry_in, and carry_out equals bit WIDTH of that sum.
- R2: With op_sel = 2'b01, {carry_out, sum_out} equals a_in + (bitwise NOT b_in) + carry_in. With carry_in = 1 this is the exact difference a_in - b_in modulo 2^WIDTH, and carry_out is 1 exactly when a_in >= b_in.
- R3: With op_sel = 2'b10, the second operand is zero. carry_in = 0 gives sum_out = a_in and carry_out = 0. carry_in = 1 gives sum_out = a_in + 1 modulo 2^WIDTH, and carry_out is 1 only when a_in is all ones.
- R4: With op_sel = 2'b11 and carry_in = 0, sum_out = a_in - 1 modulo 2^WIDTH, and carry_out is 1 unless a_in is zero.
- R5: With op_sel = 2'b11 and carry_in = 1, sum_out = a_in and carry_out = 1.
- R6: sum_out and carry_out depend only on the present inputs and change without a clock edge. carry_in acts only as the adder's carry input and never changes which operand is selected.
- R7: When HAS_REG = 1 and load_en = 1 at a rising clock edge with rst_n = 1, reg_out takes the value sum_out had before that edge.
- R8: When load_en = 0 at a rising clock edge with rst_n = 1, reg_out keeps its value whatever the other inputs do.
- R9: rst_n is a synchronous active-low reset. rst_n = 0 at a rising edge clears reg_out to zero and takes priority over load_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the result register |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | WIDTH | First operand, always on the adder's first input |
| b_in | input | WIDTH | Second operand source |
| op_sel | input | 2 | Second-operand select: 00 B, 01 NOT B, 10 zeros, 11 ones |
| carry_in | input | 1 | Adder carry input |
| load_en | input | 1 | Result register load strobe |
| sum_out | output | WIDTH | Combinational adder result |
| carry_out | output | 1 | Adder carry-out |
| reg_out | output | WIDTH | Registered result (zero when HAS_REG = 0) |

## Verification
The bench runs a 4-bit instance through every operand pair, select value and carry input. It compares sum and carry against an arithmetic model, so it catches a swapped select encoding, a missing inversion of B, or a carry-in folded into the select. The wrap cases matter most. Incrementing all ones, decrementing zero, and subtracting equal or larger operands expose an adder that drops or inverts its carry-out. The register checks cover load, hold with changing inputs, and reset while a load is requested. A register that ignores its enable or lets load win over reset gives a wrong reg_out value.

// File: rtl/arith_micro_pkg.sv
// Package: shared types for the arithmetic microoperation unit.
// Assumes: the select encoding below is fixed by the block's operation table.
package arith_micro_pkg;
    typedef enum logic [1:0] {
        YSEL_B     = 2'b00,
        YSEL_NOT_B = 2'b01,
        YSEL_ZERO  = 2'b10,
        YSEL_ONES  = 2'b11
    } ysel_e;
endpackage

// File: rtl/operand_selector.sv
// Module: operand_selector
// Chooses the adder's second operand from B, NOT B, zeros or ones.
// Assumes: sel_i is a full two-bit code; the carry input is not seen here.
module operand_selector
    import arith_micro_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] b_i,
    input  ysel_e            sel_i,
    output logic [WIDTH-1:0] y_o
);
    // Four-way operand multiplexer.
    always_comb begin
        unique case (sel_i)
            YSEL_B:     y_o = b_i;
            YSEL_NOT_B: y_o = ~b_i;
            YSEL_ZERO:  y_o = '0;
            default:    y_o = '1;
        endcase
    end
endmodule

// File: rtl/binary_adder.sv
// Module: binary_adder
// WIDTH-bit unsigned adder with carry in and carry out.
// Assumes: operands are unsigned; the carry-out is bit WIDTH of the full sum.
module binary_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] s_o,
    output logic             cout_o
);
    localparam int SUMW = WIDTH + 1;

    logic [SUMW-1:0] full_sum;

    // Widened addition so the carry-out lands in the top bit.
    always_comb begin
        full_sum = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i};
    end

    assign s_o    = full_sum[WIDTH-1:0];
    assign cout_o = full_sum[WIDTH];
endmodule

// File: rtl/result_register.sv
// Module: result_register
// Captures the adder result on a clock edge when load is requested.
// Assumes: synchronous active-low reset, reset wins over load.
module result_register #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    // Load, hold, or clear the stored result.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (load_i)
            q_o <= d_i;
    end

    AST_LOAD_TAKES_D: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (q_o == $past(d_i))); // R7
    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(q_o)); // R8
endmodule

// File: rtl/arith_micro_unit.sv
// Module: arith_micro_unit (top)
// Eight arithmetic microoperations from one adder: the select picks the
// second operand, carry_in goes straight to the adder, and an optional
// register stores the result.
// Assumes: unsigned operands; HAS_REG selects whether the register exists.
module arith_micro_unit
    import arith_micro_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter bit HAS_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [1:0]       op_sel,
    input  logic             carry_in,
    input  logic             load_en,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic [WIDTH-1:0] reg_out
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    ysel_e            ysel;
    logic [WIDTH-1:0] y_operand;

    // Convert the raw select pins into the operand code.
    always_comb ysel = ysel_e'(op_sel);

    operand_selector #(.WIDTH(WIDTH)) sel_i (
        .b_i   (b_in),
        .sel_i (ysel),
        .y_o   (y_operand)
    );

    binary_adder #(.WIDTH(WIDTH)) add_i (
        .x_i    (a_in),
        .y_i    (y_operand),
        .cin_i  (carry_in),
        .s_o    (sum_out),
        .cout_o (carry_out)
    );

    generate
        if (HAS_REG) begin : g_reg
            result_register #(.WIDTH(WIDTH)) reg_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .load_i (load_en),
                .d_i    (sum_out),
                .q_o    (reg_out)
            );
        end else begin : g_noreg
            assign reg_out = '0;
        end
    endgenerate

    AST_TRANSFER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b10 && !carry_in) |-> (sum_out == a_in && !carry_out)); // R3
    AST_TRANSFER_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b11 && carry_in) |-> (sum_out == a_in && carry_out)); // R5
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b11 && !carry_in) |-> (sum_out == a_in - 1'b1 && carry_out == (a_in != '0))); // R4
    AST_TRUE_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b01 && carry_in) |-> (sum_out == a_in - b_in && carry_out == (a_in >= b_in))); // R2
    AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b10 && carry_in && a_in == ALL_ONES) |-> (sum_out == '0 && carry_out)); // R3
endmodule

// File: tb/arith_micro_unit_tb_top.sv
module arith_micro_unit_tb_top;
    localparam int W = 4;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [1:0]   op_sel = '0;
    logic         carry_in = 1'b0;
    logic         load_en = 1'b0;
    logic [W-1:0] sum_out;
    logic         carry_out;
    logic [W-1:0] reg_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    arith_micro_unit #(.WIDTH(W), .HAS_REG(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .op_sel(op_sel), .carry_in(carry_in), .load_en(load_en),
        .sum_out(sum_out), .carry_out(carry_out), .reg_out(reg_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model(input int a, input int b, input int s, input int c);
        int y;
        case (s)
            0: y = b;
            1: y = MAXV - b;
            2: y = 0;
            default: y = MAXV;
        endcase
        return a + y + c;
    endfunction

    initial begin
        // Reset state: rst_n low with a load requested.
        load_en = 1'b1; a_in = 4'd5; b_in = 4'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset clears", int'(reg_out), 0);
        rst_n = 1'b1; load_en = 1'b0;

        // Exhaustive combinational sweep (R1..R6).
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 2; c++) begin
                for (int a = 0; a <= MAXV; a++) begin
                    for (int b = 0; b <= MAXV; b++) begin
                        int tot;
                        string rq;
                        @(negedge clk);
                        a_in = W'(a); b_in = W'(b); op_sel = 2'(s); carry_in = c[0];
                        #1;
                        tot = model(a, b, s, c);
                        case (s)
                            0: rq = "R1";
                            1: rq = "R2";
                            2: rq = "R3";
                            default: rq = (c == 0) ? "R4" : "R5";
                        endcase
                        chk({rq, " sum"}, int'(sum_out), tot & MAXV);
                        chk({rq, " carry"}, int'(carry_out), (tot >> W) & 1);
                    end
                end
            end
        end

        // R6: outputs follow a change between clock edges.
        @(negedge clk);
        op_sel = 2'b00; carry_in = 1'b0; a_in = 4'd6; b_in = 4'd7;
        #3; a_in = 4'd9;
        #1; chk("R6 comb follow", int'(sum_out), (9 + 7) & MAXV);
        chk("R6 comb carry", int'(carry_out), 1);
        // R6: carry_in does not switch the operand (sel 00, cin 1 still uses B)
        carry_in = 1'b1; #1;
        chk("R6 cin not select", int'(sum_out), (9 + 7 + 1) & MAXV);

        // R7: load 2 + 3 into the register.
        @(negedge clk);
        a_in = 4'd2; b_in = 4'd3; op_sel = 2'b00; carry_in = 1'b0; load_en = 1'b1;
        @(negedge clk);
        chk("R7 load", int'(reg_out), 5);
        // R7: subtract 9 - 4 then load.
        a_in = 4'd9; b_in = 4'd4; op_sel = 2'b01; carry_in = 1'b1;
        @(negedge clk);
        chk("R7 load sub", int'(reg_out), 5 + 0);
        a_in = 4'd1; b_in = 4'd0; op_sel = 2'b11; carry_in = 1'b0;
        @(negedge clk);
        chk("R7 load dec", int'(reg_out), 0);
        a_in = 4'd12; op_sel = 2'b10; carry_in = 1'b1;
        @(negedge clk);
        chk("R7 load inc", int'(reg_out), 13);

        // R8: hold over several edges while inputs change.
        load_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            a_in = W'(k * 3); b_in = W'(k + 5); op_sel = 2'(k); carry_in = k[0];
            @(negedge clk);
            chk("R8 hold", int'(reg_out), 13);
        end

        // R9: reset wins over load.
        a_in = 4'd7; op_sel = 2'b10; carry_in = 1'b0; load_en = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset over load", int'(reg_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 load after reset", int'(reg_out), 7);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule